// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits behind the serial bus engine of a nonvolatile memory. When a write transaction opens, the engine passes in the target word address. Each data byte that follows goes into a page buffer of `PAGE_BYTES` entries, and each entry has its own valid flag. The in-page offset advances after every accepted byte and wraps inside the page. A long burst therefore overwrites bytes it placed earlier and never spills into the neighbouring page.

On the stop strobe, the buffered bytes go to the array in one self-timed write cycle. The cycle runs only when at least one byte is held and the supply stayed good for the whole transaction. Slot k is presented to the array in the k-th busy cycle, and only slots whose valid flag is set produce a write strobe.

The busy period lasts a programmable number of clock ticks. Two lengths are available, and an input picks one per cycle. While busy, every strobe from the bus engine is dropped. A write-protect flag guards the upper half of the address space. A supply-low flag abandons the transaction it touches.

Top module: `page_commit_ctrl`

## Requirements
- R1: An open strobe loads the page from `wr_addr_i[12:5]` and the starting offset from `wr_addr_i[4:0]`. It clears every valid flag. The first accepted byte is written back at that exact address.
- R2: Each accepted byte is stored at the current offset, and the offset then increments modulo 32. Byte number 33 of a burst lands in the slot used by byte 1 and replaces its data.
- R3: An accepted byte makes `ack_o` high for exactly the one cycle after its strobe. A byte that is not accepted leaves `ack_o` low.
- R4: A stop with at least one valid byte and no lockout raises `busy_o` in the cycle after the stop. `busy_o` then stays high for exactly `WR_TICKS_STD` cycles if `slow_cycle_i` was 0 at the stop, or `WR_TICKS_LOW` cycles if it was 1.
- R5: In busy cycle k (k from 0 to 31), `mem_we_o` is high only if slot k is valid. In that cycle `mem_addr_o = {page, k}` and `mem_data_o` holds the slot's byte. No write occurs outside busy.
- R6: While busy, the open, byte and stop strobes are ignored. No acknowledge is given, the busy length does not change, and no new cycle follows.
- R7: With `wp_i` high and page bit 7 (address bit 12) set, bytes are neither acknowledged nor buffered, so a stop starts no cycle. Pages with bit 7 clear still accept bytes.
- R8: `low_vcc_i` high in any cycle of an open transaction has three effects. From that cycle on, bytes are not acknowledged. The stop commits nothing and leaves `busy_o` low. All buffered bytes are discarded.
- R9: A stop with no accepted byte, or a stop outside a transaction, leaves `busy_o` low and issues no write.
- R10: Valid flags clear at the end of a commit, on an abandoned stop, and on a second open before a stop. A later commit writes only its own bytes.
- R11: During reset, `busy_o`, `ack_o` and `mem_we_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_open_i | input | 1 | Strobe: a write transaction opens at `wr_addr_i` |
| wr_addr_i | input | ADDR_W | Word address, captured on the open strobe |
| byte_stb_i | input | 1 | Data byte strobe |
| byte_data_i | input | DATA_W | Data byte |
| stop_i | input | 1 | Stop strobe, requests the commit |
| wp_i | input | 1 | Write protect for the upper half of the address space |
| low_vcc_i | input | 1 | Supply below the programming threshold |
| slow_cycle_i | input | 1 | Selects the long write-cycle length, sampled at stop |
| busy_o | output | 1 | Self-timed write cycle in progress |
| ack_o | output | 1 | Pulse: the previous byte was accepted |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_data_o | output | DATA_W | Array write data |

## Verification
The hardest states to reach are the ones where a single transaction combines several conditions. One is a burst longer than a page, so that wrap-around overwriting and a full 32-slot commit appear together. Another is a set of strobes arriving in the middle of the busy window, which must leave the running cycle untouched. The stimulus builds these directly. It sends a 34-byte burst that starts two slots before the page end, then fires open, byte and stop strobes while that commit is still busy. Separate runs raise the supply-low flag for a single cycle, once on a data byte and once on the stop itself, to reach both abandon paths.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    PW_IDLE = 2'd0,
    PW_OPEN = 2'd1,
    PW_BUSY = 2'd2
  } pw_state_e;
endpackage

// File: rtl/pwb_seq.sv
module pwb_seq
  import pwb_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      open_i,
  input  logic      stop_i,
  input  logic      low_vcc_i,
  input  logic      any_valid_i,
  input  logic      done_i,
  output pw_state_e state_o,
  output logic      load_o,
  output logic      flush_o,
  output logic      commit_o,
  output logic      take_en_o
);
  pw_state_e st_q, st_d;
  logic      lock_q, lock_d;
  logic      lock_now;

  assign lock_now = lock_q | low_vcc_i;

  always_comb begin
    st_d     = st_q;
    lock_d   = lock_q;
    load_o   = 1'b0;
    flush_o  = 1'b0;
    commit_o = 1'b0;
    unique case (st_q)
      PW_IDLE: begin
        if (open_i) begin
          st_d    = PW_OPEN;
          lock_d  = 1'b0;
          load_o  = 1'b1;
          flush_o = 1'b1;
        end
      end
      PW_OPEN: begin
        if (open_i) begin
          // restart without stop drops the pending page
          lock_d  = 1'b0;
          load_o  = 1'b1;
          flush_o = 1'b1;
        end else if (stop_i) begin
          lock_d = 1'b0;
          if (!lock_now && any_valid_i) begin
            st_d     = PW_BUSY;
            commit_o = 1'b1;
          end else begin
            st_d    = PW_IDLE;
            flush_o = 1'b1;
          end
        end else begin
          lock_d = lock_now;
        end
      end
      PW_BUSY: begin
        if (done_i) begin
          st_d    = PW_IDLE;
          flush_o = 1'b1;
        end
      end
      default: st_d = PW_IDLE;
    endcase
  end

  assign take_en_o = (st_q == PW_OPEN) && !open_i && !stop_i && !lock_now;
  assign state_o   = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PW_IDLE;
      lock_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      lock_q <= lock_d;
    end
  end

  AST_BUSY_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PW_BUSY && !done_i) |=> (st_q == PW_BUSY)); // R6
endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
  parameter int unsigned T_STD = 40,
  parameter int unsigned T_LOW = 56,
  localparam int unsigned T_MAX = (T_STD > T_LOW) ? T_STD : T_LOW,
  localparam int unsigned CNT_W = $clog2(T_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             sel_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q, len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      len_q <= CNT_W'(T_STD);
    end else if (start_i) begin
      cnt_q <= '0;
      len_q <= sel_i ? CNT_W'(T_LOW) : CNT_W'(T_STD);
    end else if (run_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign done_o = run_i && (cnt_q == len_q - CNT_W'(1));
  assign cnt_o  = cnt_q;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < len_q)); // R4
endmodule

// File: rtl/pwb_buffer.sv
module pwb_buffer #(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned PAGE_BYTES = 32,
  localparam int unsigned OFS_W     = $clog2(PAGE_BYTES),
  localparam int unsigned PAGE_W    = ADDR_W - OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              flush_i,
  input  logic              take_en_i,
  input  logic              byte_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              wp_i,
  input  logic              scan_i,
  input  logic              scan_ok_i,
  input  logic [OFS_W-1:0]  idx_i,
  output logic              any_valid_o,
  output logic              ack_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o
);
  logic [PAGE_W-1:0] page_q;
  logic [OFS_W-1:0]  ptr_q;
  logic [DATA_W-1:0] buf_q [PAGE_BYTES];
  logic              vld_q [PAGE_BYTES];
  logic              prot, accept, ack_q;

  assign prot   = wp_i & page_q[PAGE_W-1];
  assign accept = take_en_i & byte_i & ~prot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      ptr_q  <= '0;
      ack_q  <= 1'b0;
    end else begin
      ack_q <= accept;
      if (load_i) begin
        page_q <= addr_i[ADDR_W-1:OFS_W];
        ptr_q  <= addr_i[OFS_W-1:0];
      end else if (accept) begin
        ptr_q <= ptr_q + OFS_W'(1);
      end
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = accept && (ptr_q == OFS_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        buf_q[g] <= '0;
      end else begin
        if (flush_i)  vld_q[g] <= 1'b0;
        else if (hit) vld_q[g] <= 1'b1;
        if (hit) buf_q[g] <= data_i;
      end
    end
  end

  always_comb begin
    any_valid_o = 1'b0;
    for (int i = 0; i < PAGE_BYTES; i++) any_valid_o = any_valid_o | vld_q[i];
  end

  assign ack_o      = ack_q;
  assign mem_we_o   = scan_i & scan_ok_i & vld_q[idx_i];
  assign mem_addr_o = {page_q, idx_i};
  assign mem_data_o = buf_q[idx_i];
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
  import pwb_pkg::*;
#(
  parameter int unsigned ADDR_W       = 13,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned PAGE_BYTES   = 32,
  parameter int unsigned WR_TICKS_STD = 40,
  parameter int unsigned WR_TICKS_LOW = 56,
  localparam int unsigned OFS_W       = $clog2(PAGE_BYTES),
  localparam int unsigned T_MAX       = (WR_TICKS_STD > WR_TICKS_LOW) ? WR_TICKS_STD : WR_TICKS_LOW,
  localparam int unsigned CNT_W       = $clog2(T_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_open_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              byte_stb_i,
  input  logic [DATA_W-1:0] byte_data_i,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic              low_vcc_i,
  input  logic              slow_cycle_i,
  output logic              busy_o,
  output logic              ack_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o
);
  pw_state_e        state;
  logic             load, flush, commit, take_en, any_valid, done;
  logic [CNT_W-1:0] cnt;
  logic             scan_ok;

  assign busy_o  = (state == PW_BUSY);
  assign scan_ok = (cnt < CNT_W'(PAGE_BYTES));

  pwb_seq i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .open_i      (wr_open_i),
    .stop_i      (stop_i),
    .low_vcc_i   (low_vcc_i),
    .any_valid_i (any_valid),
    .done_i      (done),
    .state_o     (state),
    .load_o      (load),
    .flush_o     (flush),
    .commit_o    (commit),
    .take_en_o   (take_en)
  );

  pwb_timer #(
    .T_STD (WR_TICKS_STD),
    .T_LOW (WR_TICKS_LOW)
  ) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (commit),
    .sel_i   (slow_cycle_i),
    .run_i   (busy_o),
    .cnt_o   (cnt),
    .done_o  (done)
  );

  pwb_buffer #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PAGE_BYTES (PAGE_BYTES)
  ) i_buffer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .addr_i      (wr_addr_i),
    .flush_i     (flush),
    .take_en_i   (take_en),
    .byte_i      (byte_stb_i),
    .data_i      (byte_data_i),
    .wp_i        (wp_i),
    .scan_i      (busy_o),
    .scan_ok_i   (scan_ok),
    .idx_i       (cnt[OFS_W-1:0]),
    .any_valid_o (any_valid),
    .ack_o       (ack_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_data_o  (mem_data_o)
  );

  AST_WE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o); // R5
  AST_NO_ACK_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !busy_o); // R6
  AST_BUSY_FROM_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i)); // R4
  AST_NO_ACK_LOWV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !$past(low_vcc_i)); // R8
  AST_BUSY_NEEDS_SUPPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !$past(low_vcc_i)); // R8
endmodule

// File: tb/test_page_commit_ctrl.sv
module test_page_commit_ctrl;
  localparam int T_STD = 40;
  localparam int T_LOW = 56;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_open_i = 1'b0;
  logic [12:0] wr_addr_i = '0;
  logic        byte_stb_i = 1'b0;
  logic [7:0]  byte_data_i = '0;
  logic        stop_i = 1'b0;
  logic        wp_i = 1'b0;
  logic        low_vcc_i = 1'b0;
  logic        slow_cycle_i = 1'b0;
  logic        busy_o, ack_o, mem_we_o;
  logic [12:0] mem_addr_o;
  logic [7:0]  mem_data_o;

  page_commit_ctrl #(.WR_TICKS_STD(T_STD), .WR_TICKS_LOW(T_LOW)) i_page_commit_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_open_i(wr_open_i), .wr_addr_i(wr_addr_i),
    .byte_stb_i(byte_stb_i), .byte_data_i(byte_data_i), .stop_i(stop_i), .wp_i(wp_i),
    .low_vcc_i(low_vcc_i), .slow_cycle_i(slow_cycle_i), .busy_o(busy_o), .ack_o(ack_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o));

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, n_ack = 0, n_wr = 0, n_bsy = 0;
  bit finished = 0;
  int seen [int];

  // reference model state
  bit m_open, m_lock, m_busy, e_ack;
  int m_page, m_ptr, m_cnt, m_len;
  int m_buf [32];
  bit m_vld [32];

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void m_clear();
    for (int i = 0; i < 32; i++) m_vld[i] = 0;
  endfunction

  function automatic bit m_any();
    for (int i = 0; i < 32; i++) if (m_vld[i]) return 1;
    return 0;
  endfunction

  function automatic void m_step();
    bit lk;
    e_ack = 0;
    if (!rst_ni) begin
      m_open = 0; m_lock = 0; m_busy = 0; m_cnt = 0; m_clear();
    end else if (m_busy) begin
      if (m_cnt == m_len - 1) begin m_busy = 0; m_clear(); end
      else m_cnt++;
    end else if (wr_open_i) begin
      m_open = 1; m_lock = 0; m_clear();
      m_page = int'(wr_addr_i) / 32; m_ptr = int'(wr_addr_i) % 32;
    end else if (m_open && stop_i) begin
      lk = m_lock || low_vcc_i;
      if (!lk && m_any()) begin
        m_busy = 1; m_cnt = 0; m_len = slow_cycle_i ? T_LOW : T_STD;
      end else m_clear();
      m_open = 0; m_lock = 0;
    end else if (m_open) begin
      lk = m_lock || low_vcc_i;
      if (byte_stb_i && !lk && !(wp_i && m_page >= 128)) begin
        m_buf[m_ptr] = int'(byte_data_i); m_vld[m_ptr] = 1;
        m_ptr = (m_ptr + 1) % 32; e_ack = 1;
      end
      m_lock = lk;
    end
  endfunction

  initial begin
    forever begin
      bit e_we;
      @(posedge clk_i);
      m_step();
      #1;
      e_we = m_busy && m_cnt < 32 && m_vld[m_cnt % 32];
      chk("R4 busy_o", int'(busy_o), int'(m_busy));
      chk("R3 ack_o", int'(ack_o), int'(e_ack));
      chk("R5 mem_we_o", int'(mem_we_o), int'(e_we));
      if (e_we && mem_we_o) begin
        chk("R5 mem_addr_o", int'(mem_addr_o), m_page * 32 + m_cnt);
        chk("R5 mem_data_o", int'(mem_data_o), m_buf[m_cnt]);
      end
      if (ack_o) n_ack++;
      if (busy_o) n_bsy++;
      if (mem_we_o) begin n_wr++; seen[int'(mem_addr_o)] = int'(mem_data_o); end
    end
  end

  task automatic do_open(input logic [12:0] a);
    @(negedge clk_i); wr_open_i = 1; wr_addr_i = a;
    @(negedge clk_i); wr_open_i = 0;
  endtask

  task automatic do_byte(input logic [7:0] d, input bit lv);
    @(negedge clk_i); byte_stb_i = 1; byte_data_i = d; low_vcc_i = lv;
    @(negedge clk_i); byte_stb_i = 0; low_vcc_i = 0;
  endtask

  task automatic do_stop(input bit slow, input bit lv);
    @(negedge clk_i); stop_i = 1; slow_cycle_i = slow; low_vcc_i = lv;
    @(negedge clk_i); stop_i = 0; low_vcc_i = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog R4 actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    int a0, w0, b0, a1;
    repeat (3) @(negedge clk_i);
    chk("R11 busy_o in reset", int'(busy_o), 0);
    chk("R11 ack_o in reset", int'(ack_o), 0);
    chk("R11 mem_we_o in reset", int'(mem_we_o), 0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);

    // page 2, offset 3, short cycle
    w0 = n_wr; b0 = n_bsy; a0 = n_ack;
    do_open(13'h043);
    for (int i = 0; i < 4; i++) do_byte(8'hA0 + 8'(i), 0);
    do_stop(0, 0);
    wait_idle();
    chk("R3 acks", n_ack - a0, 4);
    chk("R5 write count", n_wr - w0, 4);
    chk("R1 first byte at start offset", seen[32'h043], 32'hA0);
    chk("R1 last byte", seen[32'h046], 32'hA3);
    chk("R4 short busy length", n_bsy - b0, T_STD);

    // page 5, 34-byte burst from offset 30, long cycle; strobes during busy
    w0 = n_wr; b0 = n_bsy; a0 = n_ack;
    do_open(13'd190);
    for (int i = 0; i < 34; i++) do_byte(8'h10 + 8'(i), 0);
    chk("R3 burst acks", n_ack - a0, 34);
    do_stop(1, 0);
    a1 = n_ack;
    do_open(13'h100);
    do_byte(8'hEE, 0);
    do_stop(0, 0);
    wait_idle();
    chk("R2 wrap overwrite slot 30", seen[5 * 32 + 30], 32'h30);
    chk("R2 wrap overwrite slot 31", seen[5 * 32 + 31], 32'h31);
    chk("R2 slot 0 after wrap", seen[5 * 32 + 0], 32'h12);
    chk("R5 full page writes", n_wr - w0, 32);
    chk("R4 long busy length", n_bsy - b0, T_LOW);
    chk("R6 no ack while busy", n_ack - a1, 0);
    chk("R6 no write to ignored page", int'(seen.exists(32'h100)), 0);
    chk("R6 no cycle after busy", int'(busy_o), 0);

    // flags cleared after commit
    w0 = n_wr;
    do_open(13'h200);
    do_byte(8'h77, 0);
    do_stop(0, 0);
    wait_idle();
    chk("R10 only own byte written", n_wr - w0, 1);
    chk("R10 data", seen[32'h200], 32'h77);

    // write protect on upper page, then on lower page
    wp_i = 1;
    w0 = n_wr; b0 = n_bsy; a0 = n_ack;
    do_open(13'h1005);
    for (int i = 0; i < 3; i++) do_byte(8'h60 + 8'(i), 0);
    do_stop(0, 0);
    wait_idle();
    chk("R7 no ack on protected page", n_ack - a0, 0);
    chk("R7 no busy on protected page", n_bsy - b0, 0);
    chk("R7 no write on protected page", n_wr - w0, 0);
    w0 = n_wr; a0 = n_ack;
    do_open(13'h0FE0);
    do_byte(8'h5A, 0);
    do_stop(0, 0);
    wait_idle();
    chk("R7 lower page acked", n_ack - a0, 1);
    chk("R7 lower page written", seen[32'h0FE0], 32'h5A);
    wp_i = 0;

    // supply dip on a data byte
    w0 = n_wr; b0 = n_bsy; a0 = n_ack;
    do_open(13'h300);
    do_byte(8'h51, 0);
    do_byte(8'h52, 1);
    do_byte(8'h53, 0);
    do_stop(0, 0);
    wait_idle();
    chk("R8 acks before dip only", n_ack - a0, 1);
    chk("R8 no busy after dip", n_bsy - b0, 0);
    chk("R8 no write after dip", n_wr - w0, 0);

    // supply dip on the stop itself
    b0 = n_bsy;
    do_open(13'h320);
    do_byte(8'h61, 0);
    do_stop(0, 1);
    wait_idle();
    chk("R8 dip at stop", n_bsy - b0, 0);

    // empty transaction and stray stop
    b0 = n_bsy; w0 = n_wr;
    do_open(13'h340);
    do_stop(0, 0);
    wait_idle();
    do_stop(0, 0);
    wait_idle();
    chk("R9 no busy without data", n_bsy - b0, 0);
    chk("R9 no write without data", n_wr - w0, 0);

    // restart discards pending bytes
    w0 = n_wr;
    do_open(13'h400);
    do_byte(8'h91, 0);
    do_byte(8'h92, 0);
    do_open(13'h420);
    do_byte(8'h99, 0);
    do_stop(0, 0);
    wait_idle();
    chk("R10 restart writes one byte", n_wr - w0, 1);
    chk("R10 restart data", seen[32'h420], 32'h99);
    chk("R10 dropped bytes absent", int'(seen.exists(32'h400)), 0);

    finish_run();
  end
endmodule